// File: doc/BRIEF.md
# Per-Context Threshold Priority Arbiter

This block decides, for every interrupt target context, which interrupt source that context should service next. It takes one vector each of pending and claimed flags shared by all contexts, a separate enable vector for each context, a small priority value for each source and a threshold for each context. For each context it produces the identifier of the winning source and a request line that drives the external interrupt input of the hart and privilege mode bound to that context.

A source competes for a context only when it is pending, enabled for that context and not already claimed. It must also carry a priority strictly above that context's threshold. The highest priority wins, and on a tie the lowest identifier wins. Identifier 0 is reserved to mean "nothing to service", so source 0 never competes and the request line is simply the identifier being nonzero. Claim handling and register decoding belong to surrounding logic. The result is registered, so outputs follow the inputs one clock later.

There is no state machine: each context has a single pair of output registers, cleared by the active-low reset and loaded on every rising clock edge.

Top module: `ctx_irq_arbiter`

## Requirements
- R1: A source competes for a context only when its pending bit is 1, its enable bit for that context (ctx_enable bit c*NUM_SRC+i) is 1 and its claimed bit is 0; clearing any one of these removes it.
- R2: A competing source wins only if its priority (src_prio bits i*PRIO_W upward) is strictly greater than the context threshold (ctx_thresh bits c*PRIO_W upward); a priority equal to the threshold does not win.
- R3: Among the sources that pass R1 and R2, the one with the highest priority wins; among equal priorities the lowest source identifier wins.
- R4: When no source passes R1 and R2 the context's identifier (win_id bits c*ID_W upward) is 0.
- R5: ctx_irq bit c is 1 exactly when the identifier of context c is nonzero.
- R6: A source with priority 0 never wins, whatever the other inputs are.
- R7: Source 0 never wins, whatever its pending, claimed, enable and priority bits are.
- R8: Outputs reflect the inputs sampled at the previous rising clock edge; while rst_n is 0 every identifier and request line is 0.
- R9: Each context uses only its own enable bits and its own threshold; contexts do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, synchronous |
| src_pending | input | NUM_SRC | Pending flag per source, bit i for source i |
| src_claimed | input | NUM_SRC | Claimed flag per source, bit i for source i |
| ctx_enable | input | NUM_CTX*NUM_SRC | Enable flags, bit c*NUM_SRC+i enables source i for context c |
| src_prio | input | NUM_SRC*PRIO_W | Priority of source i in bits i*PRIO_W upward |
| ctx_thresh | input | NUM_CTX*PRIO_W | Threshold of context c in bits c*PRIO_W upward |
| win_id | output | NUM_CTX*ID_W | Winning source of context c in bits c*ID_W upward, 0 for none |
| ctx_irq | output | NUM_CTX | Request line of context c, high when its identifier is nonzero |

## Verification
The only state is the registered winner per context, so a wrong value shows at win_id and ctx_irq one clock after the inputs that caused it and persists until the inputs change. A flaw in eligibility, threshold comparison or tie-breaking shows as a wrong identifier on a specific pattern, which is why the inputs are swept across every threshold with many mixed pending, claimed, enable and priority patterns. A mismatch between the request line and the identifier is visible in the same cycle as the identifier.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Width of a source identifier able to name every source.
    function automatic int id_width(input int n_src);
        return (n_src <= 2) ? 1 : $clog2(n_src);
    endfunction

endpackage

// File: rtl/src_eligible.sv
module src_eligible #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] pending,
    input  logic [NUM_SRC-1:0] claimed,
    input  logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] elig
);

    // Identifier 0 is reserved as "no source", so bit 0 is forced low.
    assign elig[0] = 1'b0;

    for (genvar i = 1; i < NUM_SRC; i++) begin : g_bit
        assign elig[i] = pending[i] & enable[i] & ~claimed[i];
    end

    // Source 0 bits feed nothing; keep them referenced for completeness.
    logic src0_unused;
    assign src0_unused = pending[0] ^ claimed[0] ^ enable[0];

endmodule

// File: rtl/ctx_pick.sv
module ctx_pick #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        elig,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         thresh,
    output logic [ID_W-1:0]           pick_id,
    output logic                      pick_valid
);

    logic [PRIO_W-1:0] best_prio;

    // Ascending scan with a strict compare: a later source replaces the
    // current best only with a higher priority, so ties keep the lower ID.
    always_comb begin
        best_prio  = thresh;
        pick_id    = '0;
        pick_valid = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i != 0 && elig[i] &&
                prio_flat[i*PRIO_W +: PRIO_W] > best_prio) begin
                best_prio  = prio_flat[i*PRIO_W +: PRIO_W];
                pick_id    = ID_W'(i);
                pick_valid = 1'b1;
            end
        end
    end

    logic [PRIO_W-1:0] picked_prio;
    always_comb begin
        picked_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pick_id == ID_W'(i)) picked_prio = prio_flat[i*PRIO_W +: PRIO_W];
        end
    end

    // R6
    zero_prio_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> picked_prio != '0);

    // R7
    src0_never_picked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> pick_id != '0);

endmodule

// File: rtl/ctx_irq_arbiter.sv
module ctx_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter  int NUM_SRC = 32,
    parameter  int NUM_CTX = 4,
    parameter  int PRIO_W  = 3,
    localparam int ID_W    = id_width(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pending,
    input  logic [NUM_SRC-1:0]        src_claimed,
    input  logic [NUM_CTX*NUM_SRC-1:0] ctx_enable,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_CTX*PRIO_W-1:0] ctx_thresh,
    output logic [NUM_CTX*ID_W-1:0]   win_id,
    output logic [NUM_CTX-1:0]        ctx_irq
);

    logic [NUM_SRC-1:0] elig_w [NUM_CTX];

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic [ID_W-1:0] pick_id;
        logic            pick_valid;
        logic [ID_W-1:0] win_q;
        logic            irq_q;

        src_eligible #(.NUM_SRC(NUM_SRC)) u_elig (
            .pending (src_pending),
            .claimed (src_claimed),
            .enable  (ctx_enable[c*NUM_SRC +: NUM_SRC]),
            .elig    (elig_w[c])
        );

        ctx_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
            .clk        (clk),
            .rst_n      (rst_n),
            .elig       (elig_w[c]),
            .prio_flat  (src_prio),
            .thresh     (ctx_thresh[c*PRIO_W +: PRIO_W]),
            .pick_id    (pick_id),
            .pick_valid (pick_valid)
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q <= '0;
                irq_q <= 1'b0;
            end else begin
                win_q <= pick_id;
                irq_q <= pick_valid;
            end
        end

        assign win_id[c*ID_W +: ID_W] = win_q;
        assign ctx_irq[c]             = irq_q;
    end

    // ------------------------------------------------------------------
    // Checker state: snapshot of the inputs the outputs were built from,
    // with the best qualifying priority found by a separate max search.
    // ------------------------------------------------------------------
    logic [PRIO_W-1:0]  prio_q   [NUM_SRC];
    logic [PRIO_W-1:0]  thresh_q [NUM_CTX];
    logic [NUM_SRC-1:0] elig_q   [NUM_CTX];
    logic [PRIO_W-1:0]  max_c    [NUM_CTX];
    logic [PRIO_W-1:0]  max_q    [NUM_CTX];
    logic [NUM_CTX-1:0] any_c, any_q;

    always_comb begin
        for (int c = 0; c < NUM_CTX; c++) begin
            any_c[c] = 1'b0;
            max_c[c] = '0;
            for (int i = 1; i < NUM_SRC; i++) begin
                if (src_pending[i] && !src_claimed[i] && ctx_enable[c*NUM_SRC+i] &&
                    src_prio[i*PRIO_W +: PRIO_W] > ctx_thresh[c*PRIO_W +: PRIO_W]) begin
                    any_c[c] = 1'b1;
                    if (src_prio[i*PRIO_W +: PRIO_W] > max_c[c])
                        max_c[c] = src_prio[i*PRIO_W +: PRIO_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                thresh_q[c] <= '0;
                elig_q[c]   <= '0;
                max_q[c]    <= '0;
            end
        end else begin
            any_q <= any_c;
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= src_prio[i*PRIO_W +: PRIO_W];
            for (int c = 0; c < NUM_CTX; c++) begin
                thresh_q[c] <= ctx_thresh[c*PRIO_W +: PRIO_W];
                elig_q[c]   <= elig_w[c];
                max_q[c]    <= max_c[c];
            end
        end
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
        logic [ID_W-1:0] w;
        assign w = win_id[c*ID_W +: ID_W];

        // R1
        win_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (w != '0) |-> elig_q[c][w]);

        // R2
        win_above_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (w != '0) |-> prio_q[w] > thresh_q[c]);

        // R3
        win_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (w != '0) |-> prio_q[w] == max_q[c]);

        // R4
        none_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !any_q[c] |-> w == '0);

        // R8
        found_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            any_q[c] |-> w != '0);

        // R5
        irq_tracks_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctx_irq[c] == (w != '0));
    end

endmodule

// File: tb/tb_ctx_irq_arbiter.sv
`timescale 1ns/1ps
module tb_ctx_irq_arbiter;

    localparam int NS = 8;
    localparam int NC = 2;
    localparam int PW = 3;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     pend = '0;
    logic [NS-1:0]     clm = '0;
    logic [NC*NS-1:0]  en = '0;
    logic [NS*PW-1:0]  pr = '0;
    logic [NC*PW-1:0]  th = '0;
    logic [NC*IW-1:0]  win_id;
    logic [NC-1:0]     ctx_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    ctx_irq_arbiter #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .src_pending(pend), .src_claimed(clm),
        .ctx_enable(en), .src_prio(pr), .ctx_thresh(th),
        .win_id(win_id), .ctx_irq(ctx_irq)
    );

    // Expected winner: find the top qualifying priority, then the first ID holding it.
    function automatic int expect_id(input int c);
        int top = -1;
        for (int i = 1; i < NS; i++) begin
            int p = int'(pr[i*PW +: PW]);
            if (pend[i] && !clm[i] && en[c*NS+i] && p > int'(th[c*PW +: PW]) && p > top)
                top = p;
        end
        if (top < 0) return 0;
        for (int i = 1; i < NS; i++) begin
            if (pend[i] && !clm[i] && en[c*NS+i] && int'(pr[i*PW +: PW]) == top)
                return i;
        end
        return 0;
    endfunction

    task automatic check_ctx(input int c, input int exp_id, input string tag);
        int got = int'(win_id[c*IW +: IW]);
        n_tests++;
        if (got != exp_id) begin
            n_fail++;
            $display("FAIL %s ctx%0d id: actual %0d expected %0d", tag, c, got, exp_id);
        end
        n_tests++;
        if (ctx_irq[c] != (exp_id != 0)) begin
            n_fail++;
            $display("FAIL R5 (%s) ctx%0d irq: actual %0b expected %0b",
                     tag, c, ctx_irq[c], exp_id != 0);
        end
    endtask

    task automatic settle_and_check(input string tag);
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) check_ctx(c, expect_id(c), tag);
    endtask

    function automatic logic [NS*PW-1:0] all_prio(input int v);
        logic [NS*PW-1:0] r;
        for (int i = 0; i < NS; i++) r[i*PW +: PW] = PW'(v);
        return r;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        // R8: reset holds outputs at zero even with a winning pattern present
        pend = 8'hFF; en = '1; pr = all_prio(5); th = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) check_ctx(c, 0, "R8 reset");
        rst_n = 1'b1;
        settle_and_check("R3 tie all equal");

        // R7: only source 0 active, at top priority
        @(negedge clk);
        pend = 8'h01; clm = '0; en = '1; pr = all_prio(7); th = '0;
        settle_and_check("R7 source0");
        for (int c = 0; c < NC; c++) check_ctx(c, 0, "R7 source0 direct");

        // R6: everything pending at priority 0, threshold 0
        @(negedge clk);
        pend = 8'hFF; pr = all_prio(0);
        settle_and_check("R6 prio0");
        for (int c = 0; c < NC; c++) check_ctx(c, 0, "R6 prio0 direct");

        // R2: priority equal to threshold loses, one above wins
        @(negedge clk);
        pend = 8'b0000_1000; pr = '0; pr[3*PW +: PW] = 3'd4; th = {3'd4, 3'd4};
        settle_and_check("R2 equal");
        for (int c = 0; c < NC; c++) check_ctx(c, 0, "R2 equal direct");
        @(negedge clk);
        th = {3'd3, 3'd3};
        settle_and_check("R2 above");
        for (int c = 0; c < NC; c++) check_ctx(c, 3, "R2 above direct");

        // R3: tie on 2 and 5 goes to 2; a higher priority on 6 beats both
        @(negedge clk);
        pend = 8'b0110_0100; th = '0; pr = '0;
        pr[2*PW +: PW] = 3'd6; pr[5*PW +: PW] = 3'd6; pr[6*PW +: PW] = 3'd1;
        settle_and_check("R3 tie");
        check_ctx(0, 2, "R3 tie direct");
        @(negedge clk);
        pr[6*PW +: PW] = 3'd7;
        settle_and_check("R3 highest");
        check_ctx(0, 6, "R3 highest direct");

        // R1: claiming or disabling the winner passes to the next one
        @(negedge clk);
        clm = 8'b0100_0000;
        settle_and_check("R1 claimed");
        check_ctx(0, 2, "R1 claimed direct");
        @(negedge clk);
        en[0*NS+2] = 1'b0;
        settle_and_check("R1 disabled");
        check_ctx(0, 5, "R1 disabled direct");
        check_ctx(1, 2, "R9 other ctx keeps 2");
        @(negedge clk);
        pend[5] = 1'b0;
        settle_and_check("R4 none left");
        check_ctx(0, 0, "R4 none left direct");

        // R9: separate enables and thresholds per context
        @(negedge clk);
        clm = '0; pend = 8'b0001_0010; pr = '0;
        pr[1*PW +: PW] = 3'd2; pr[4*PW +: PW] = 3'd5;
        en = '0; en[0*NS+1] = 1'b1; en[0*NS+4] = 1'b1; en[1*NS+1] = 1'b1;
        th = {3'd1, 3'd4};
        settle_and_check("R9 split");
        check_ctx(0, 4, "R9 ctx0");
        check_ctx(1, 1, "R9 ctx1");

        // R8: one clock of latency - old value before the edge, new after
        @(negedge clk);
        th = {3'd2, 3'd5};
        #5;
        check_ctx(0, 4, "R8 before edge");
        check_ctx(1, 1, "R8 before edge");
        @(posedge clk);
        @(negedge clk);
        check_ctx(0, 0, "R8 after edge");
        check_ctx(1, 0, "R8 after edge");

        // Sweep: every threshold pair against pseudo-random patterns
        for (int t0 = 0; t0 < 8; t0++) begin
            for (int t1 = 0; t1 < 8; t1++) begin
                for (int k = 0; k < 24; k++) begin
                    @(negedge clk);
                    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                    pend = lfsr[7:0] | lfsr[15:8];
                    clm  = lfsr[23:16] & lfsr[31:24];
                    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                    en   = lfsr[15:0] | lfsr[31:16];
                    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                    pr   = lfsr[NS*PW-1:0];
                    th   = {PW'(t1), PW'(t0)};
                    settle_and_check("R1/R2/R3/R4 sweep");
                end
            end
        end

        // R8: reset reasserted clears the outputs
        @(negedge clk);
        pend = '1; clm = '0; en = '1; pr = all_prio(7); th = '0; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) check_ctx(c, 0, "R8 reset again");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule